// File: doc/BRIEF.md
# Multi-Rate Serial Channel Bridge

This block joins one host-side asynchronous serial link to four downstream serial links. Each downstream link runs at its own baud rate, and all four can be active at the same moment. The host sends two kinds of header byte. One sets the baud rate of a channel. The other announces a payload byte for a channel.

Each payload byte waits in its channel's 64-byte transmit queue. It goes out as an 8N1 frame only after that channel has a rate. Bytes that arrive on a downstream input are stored in that channel's 64-byte receive queue. The host side drains these queues in rotating channel order. Each returned byte is preceded by a tag byte that names its channel.

Everything runs on one system clock. Every serial input passes through a two-flop synchronizer. Each bit clock is a 16x oversampling tick made by dividing the system clock.

Top module: `serial_fanout_bridge`

## Requirements
- R1: After reset, `host_txd` and every bit of `ch_txd` are high, every queue is empty and no frame is produced.
- R2: A host header byte `11xx_ccpp` gives channel `cc` the rate code `pp`, where code 0 = 9600, 1 = 19200, 2 = 57600 and 3 = 115200 baud. The oversampling tick divisor is CLK_HZ/(16*baud).
- R3: A host header byte `10xx_xxcc` makes the next host byte a payload for channel `cc`, and that byte is written to that channel's transmit queue. A header whose top two bits are `00` or `01` is ignored and has no effect on any output.
- R4: A channel that has not been given a rate keeps its payload queued, holds its `ch_txd` line high and ignores its `ch_rxd` input. Once its rate is set, it sends the held bytes in their arrival order.
- R5: Each downstream frame is one low start bit, eight data bits sent LSB first, and one high stop bit. Every bit lasts 16 ticks of the channel's divisor.
- R6: Each queue holds 64 bytes. A write to a full transmit queue is dropped, so a channel that is sent 66 payload bytes before its rate is set later emits only the first 64.
- R7: The four channels transmit at the same time, each at its own configured rate.
- R8: A byte received on a configured channel is returned on `host_txd` as a tag byte equal to the channel number (bits 7:2 zero), followed by the data byte.
- R9: When several receive queues hold data, the channel served next is the first non-empty one after the channel served last, wrapping from 3 back to 0.
- R10: `host_rxd` and `host_txd` run at the fixed rate given by the HOST_BAUD parameter, using 8N1 framing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rxd | input | 1 | Serial data from the host |
| ch_rxd | input | 4 | Serial data from the four downstream devices |
| host_txd | output | 1 | Serial data to the host (tag byte and data byte pairs) |
| ch_txd | output | 4 | Serial data to the four downstream devices |

## Verification
A downstream frame starts one cycle after its byte leaves the transmit queue. The exact start cycle depends on tick phase and on host command timing, so the line monitors lock onto each falling start edge instead of a fixed cycle count. From that edge they sample the start bit, the data bits and the stop bit at the middles of the bits, using the bit length that the configured rate code implies. A wrong divisor or a wrong bit order therefore shows up as a bad byte.

A returned pair starts on `host_txd` within a few ticks of the middle of the downstream stop bit, when the host transmitter is idle. The round-robin case is timed so that two channels are both pending each time the host link becomes free. Checks that something is absent wait well past several frame lengths before reading the line levels and the per-line frame counts.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int NUM_CH = 4;
    localparam int CH_W   = 2;
    localparam int OVS    = 16;
    localparam int PH_W   = $clog2(OVS);

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        HDR_IGNORE = 2'd0,
        HDR_SELECT = 2'd1,
        HDR_RATE   = 2'd2
    } hdr_kind_e;

    typedef struct packed {
        hdr_kind_e       kind;
        logic [CH_W-1:0] chan;
        logic [1:0]      code;
    } host_cmd_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    typedef enum logic {
        RET_IDLE = 1'b0,
        RET_DATA = 1'b1
    } ret_state_e;

    function automatic host_cmd_t decode_hdr(byte_t b);
        host_cmd_t c;
        c.code = b[1:0];
        case (b[7:6])
            2'b11: begin c.kind = HDR_RATE;   c.chan = b[3:2]; end
            2'b10: begin c.kind = HDR_SELECT; c.chan = b[1:0]; end
            default: begin c.kind = HDR_IGNORE; c.chan = '0; end
        endcase
        return c;
    endfunction

    function automatic int unsigned preset_baud(logic [1:0] code);
        case (code)
            2'd0:    return 9600;
            2'd1:    return 19200;
            2'd2:    return 57600;
            default: return 115200;
        endcase
    endfunction

    function automatic int unsigned tick_div(int unsigned clk_hz, int unsigned baud);
        int unsigned d;
        d = clk_hz / (OVS * baud);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic logic [CH_W-1:0] rr_pick(logic [NUM_CH-1:0] req,
                                                logic [CH_W-1:0] start_at);
        logic [CH_W-1:0] idx;
        logic [CH_W-1:0] sel;
        sel = start_at;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            idx = start_at + CH_W'(k);
            if (req[idx]) sel = idx;
        end
        return sel;
    endfunction

endpackage

// File: rtl/baud_tick.sv
module baud_tick #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div - DIV_W'(1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import bridge_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  start,
    input  byte_t data,
    output logic  busy,
    output logic  txd
);
    logic [9:0]      shreg;
    logic [PH_W-1:0] phase;
    logic [3:0]      nbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            busy  <= 1'b0;
            phase <= '0;
            nbit  <= '0;
        end else if (!busy) begin
            if (start) begin
                shreg <= {1'b1, data, 1'b0};
                busy  <= 1'b1;
                phase <= '0;
                nbit  <= '0;
            end
        end else if (tick) begin
            if (phase == PH_W'(OVS - 1)) begin
                phase <= '0;
                if (nbit == 4'd9) begin
                    busy  <= 1'b0;
                    shreg <= '1;
                end else begin
                    shreg <= {1'b1, shreg[9:1]};
                    nbit  <= nbit + 4'd1;
                end
            end else begin
                phase <= phase + PH_W'(1);
            end
        end
    end

    assign txd = shreg[0];
endmodule

// File: rtl/serial_rx.sv
module serial_rx
    import bridge_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  tick,
    input  logic  rxd_raw,
    output logic  valid,
    output byte_t data
);
    logic            sync1, sync2;
    rx_state_e       state;
    logic [PH_W-1:0] phase;
    logic [2:0]      nbit;
    byte_t           shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= rxd_raw;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            phase <= '0;
            nbit  <= '0;
            shreg <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (!en) begin
                state <= RX_IDLE;
            end else if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!sync2) begin
                            state <= RX_START;
                            phase <= '0;
                        end
                    end
                    RX_START: begin
                        if (phase == PH_W'(OVS / 2 - 1)) begin
                            phase <= '0;
                            nbit  <= '0;
                            state <= sync2 ? RX_IDLE : RX_DATA;
                        end else begin
                            phase <= phase + PH_W'(1);
                        end
                    end
                    RX_DATA: begin
                        if (phase == PH_W'(OVS - 1)) begin
                            phase <= '0;
                            shreg <= {sync2, shreg[7:1]};
                            if (nbit == 3'd7) state <= RX_STOP;
                            else              nbit  <= nbit + 3'd1;
                        end else begin
                            phase <= phase + PH_W'(1);
                        end
                    end
                    default: begin
                        if (phase == PH_W'(OVS - 1)) begin
                            phase <= '0;
                            state <= RX_IDLE;
                            valid <= sync2;
                        end else begin
                            phase <= phase + PH_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    assign data = shreg;
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo
    import bridge_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  byte_t din,
    input  logic  pop,
    output byte_t dout,
    output logic  full,
    output logic  empty
);
    localparam int AW = $clog2(DEPTH);

    byte_t       mem [DEPTH];
    logic [AW:0] wptr, rptr;
    logic        do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr[AW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push) wptr <= wptr + (AW+1)'(1);
            if (do_pop)  rptr <= rptr + (AW+1)'(1);
        end
    end

    assign empty = (wptr == rptr);
    assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    assign dout  = mem[rptr[AW-1:0]];
endmodule

// File: rtl/serial_fanout_bridge.sv
module serial_fanout_bridge
    import bridge_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int HOST_BAUD  = 115200,
    parameter int FIFO_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rxd,
    input  logic [NUM_CH-1:0] ch_rxd,
    output logic              host_txd,
    output logic [NUM_CH-1:0] ch_txd
);
    localparam int HOST_DIV = tick_div(CLK_HZ, HOST_BAUD);
    localparam int SLOW_DIV = tick_div(CLK_HZ, 9600);
    localparam int MAX_DIV  = (HOST_DIV > SLOW_DIV) ? HOST_DIV : SLOW_DIV;
    localparam int DIV_W    = $clog2(MAX_DIV + 1);

    // divisor table, one entry per rate code
    logic [DIV_W-1:0] preset_div [4];
    for (genvar p = 0; p < 4; p++) begin : g_preset
        assign preset_div[p] = DIV_W'(tick_div(CLK_HZ, preset_baud(2'(p))));
    end

    // host link
    logic  host_tick, hrx_valid, htx_busy, htx_start;
    byte_t hrx_data, htx_data;

    baud_tick #(.DIV_W(DIV_W)) u_host_tick (
        .clk(clk), .rst(rst), .en(1'b1), .div(DIV_W'(HOST_DIV)), .tick(host_tick)
    );
    serial_rx u_host_rx (
        .clk(clk), .rst(rst), .en(1'b1), .tick(host_tick), .rxd_raw(host_rxd),
        .valid(hrx_valid), .data(hrx_data)
    );
    serial_tx u_host_tx (
        .clk(clk), .rst(rst), .tick(host_tick), .start(htx_start), .data(htx_data),
        .busy(htx_busy), .txd(host_txd)
    );

    // command decoder
    host_cmd_t         hdr;
    logic              pend;
    logic [CH_W-1:0]   pend_ch;
    logic [1:0]        rate [NUM_CH];
    logic [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0] txf_push;

    assign hdr = decode_hdr(hrx_data);

    always_comb begin
        txf_push = '0;
        if (hrx_valid && pend) txf_push[pend_ch] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            pend_ch <= '0;
            cfg     <= '0;
            for (int i = 0; i < NUM_CH; i++) rate[i] <= '0;
        end else if (hrx_valid) begin
            if (pend) begin
                pend <= 1'b0;
            end else begin
                case (hdr.kind)
                    HDR_RATE: begin
                        cfg[hdr.chan]  <= 1'b1;
                        rate[hdr.chan] <= hdr.code;
                    end
                    HDR_SELECT: begin
                        pend    <= 1'b1;
                        pend_ch <= hdr.chan;
                    end
                    default: ;
                endcase
            end
        end
    end

    // downstream channels
    logic [NUM_CH-1:0] ch_tick, ctx_busy, crx_valid;
    logic [NUM_CH-1:0] txf_pop, txf_full, txf_empty;
    logic [NUM_CH-1:0] rxf_pop, rxf_full, rxf_empty;
    byte_t             txf_dout [NUM_CH];
    byte_t             rxf_dout [NUM_CH];
    byte_t             crx_data [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        baud_tick #(.DIV_W(DIV_W)) u_tick (
            .clk(clk), .rst(rst), .en(cfg[c]), .div(preset_div[rate[c]]), .tick(ch_tick[c])
        );
        byte_fifo #(.DEPTH(FIFO_DEPTH)) u_txq (
            .clk(clk), .rst(rst), .push(txf_push[c]), .din(hrx_data),
            .pop(txf_pop[c]), .dout(txf_dout[c]), .full(txf_full[c]), .empty(txf_empty[c])
        );
        assign txf_pop[c] = cfg[c] && !txf_empty[c] && !ctx_busy[c];
        serial_tx u_tx (
            .clk(clk), .rst(rst), .tick(ch_tick[c]), .start(txf_pop[c]), .data(txf_dout[c]),
            .busy(ctx_busy[c]), .txd(ch_txd[c])
        );
        serial_rx u_rx (
            .clk(clk), .rst(rst), .en(cfg[c]), .tick(ch_tick[c]), .rxd_raw(ch_rxd[c]),
            .valid(crx_valid[c]), .data(crx_data[c])
        );
        byte_fifo #(.DEPTH(FIFO_DEPTH)) u_rxq (
            .clk(clk), .rst(rst), .push(crx_valid[c]), .din(crx_data[c]),
            .pop(rxf_pop[c]), .dout(rxf_dout[c]), .full(rxf_full[c]), .empty(rxf_empty[c])
        );
    end

    // return path: tag byte then data byte, rotating channel order
    ret_state_e      ret_state;
    logic [CH_W-1:0] rr_ptr, gnt, pick;

    assign pick = rr_pick(~rxf_empty, rr_ptr);

    always_comb begin
        htx_start = 1'b0;
        htx_data  = '0;
        rxf_pop   = '0;
        if (!htx_busy) begin
            if (ret_state == RET_IDLE) begin
                if (rxf_empty != '1) begin
                    htx_start = 1'b1;
                    htx_data  = byte_t'(pick);
                end
            end else begin
                htx_start    = 1'b1;
                htx_data     = rxf_dout[gnt];
                rxf_pop[gnt] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ret_state <= RET_IDLE;
            rr_ptr    <= '0;
            gnt       <= '0;
        end else if (!htx_busy) begin
            if (ret_state == RET_IDLE) begin
                if (rxf_empty != '1) begin
                    gnt       <= pick;
                    ret_state <= RET_DATA;
                end
            end else begin
                rr_ptr    <= gnt + CH_W'(1);
                ret_state <= RET_IDLE;
            end
        end
    end
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker
    import bridge_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] cfg,
    input logic [NUM_CH-1:0] ch_txd,
    input logic [NUM_CH-1:0] txf_push,
    input logic [NUM_CH-1:0] txf_pop,
    input logic [NUM_CH-1:0] txf_full,
    input logic [NUM_CH-1:0] txf_empty,
    input logic [NUM_CH-1:0] crx_valid,
    input logic [NUM_CH-1:0] rxf_pop,
    input logic [NUM_CH-1:0] rxf_full,
    input logic [NUM_CH-1:0] rxf_empty
);
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&txf_empty) && (&rxf_empty));

    p_hold_unconfigured_r4: assert property (@(posedge clk) disable iff (rst)
        ((txf_pop & ~cfg) == '0) && ((~cfg & ~ch_txd) == '0));

    p_no_receive_unconfigured_r4: assert property (@(posedge clk) disable iff (rst)
        (crx_valid & ~cfg) == '0);

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        ((txf_full & txf_empty) == '0) && ((rxf_full & rxf_empty) == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_q
        p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
            txf_full[i] && txf_push[i] && !txf_pop[i] |=> txf_full[i]);
        p_rx_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
            rxf_full[i] && crx_valid[i] && !rxf_pop[i] |=> rxf_full[i]);
    end
endmodule

bind serial_fanout_bridge bridge_checker u_bridge_checker (
    .clk(clk), .rst(rst), .cfg(cfg), .ch_txd(ch_txd),
    .txf_push(txf_push), .txf_pop(txf_pop), .txf_full(txf_full), .txf_empty(txf_empty),
    .crx_valid(crx_valid), .rxf_pop(rxf_pop), .rxf_full(rxf_full), .rxf_empty(rxf_empty)
);

// File: tb/tb_serial_fanout_bridge.sv
module tb_serial_fanout_bridge;
    localparam int CLK_HZ    = 3_686_400;
    localparam int HOST_BAUD = 115200;
    localparam int HBIT      = 16 * (CLK_HZ / (16 * HOST_BAUD));
    localparam int HOSTLINE  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_rxd = 1'b1;
    logic [3:0] ch_rxd = 4'hF;
    logic       host_txd;
    logic [3:0] ch_txd;

    always #2.5 clk = ~clk;

    serial_fanout_bridge #(.CLK_HZ(CLK_HZ), .HOST_BAUD(HOST_BAUD)) dut (
        .clk(clk), .rst(rst), .host_rxd(host_rxd), .ch_rxd(ch_rxd),
        .host_txd(host_txd), .ch_txd(ch_txd)
    );

    int n_checks = 0;
    int n_bad    = 0;
    int ch_bit [4];
    int ch_frames [4];
    int host_frames = 0;
    logic [7:0] ch_q [4][$];
    logic [7:0] host_q [$];
    bit finished = 0;

    task automatic check(bit cond, string req, string what, int act, int exp);
        n_checks++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bit_clks(int code);
        int baud;
        case (code)
            0: baud = 9600;
            1: baud = 19200;
            2: baud = 57600;
            default: baud = 115200;
        endcase
        return 16 * (CLK_HZ / (16 * baud));
    endfunction

    task automatic set_line(int line, logic v);
        if (line == HOSTLINE) host_rxd = v;
        else                  ch_rxd[line] = v;
    endtask

    task automatic send_frame(int line, int bclk, logic [7:0] b);
        set_line(line, 1'b0);
        repeat (bclk) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            set_line(line, b[i]);
            repeat (bclk) @(negedge clk);
        end
        set_line(line, 1'b1);
        repeat (bclk) @(negedge clk);
    endtask

    // driver tasks: push expectations into the scoreboard, then stimulate
    task automatic send_payload(int c, logic [7:0] b, bit expect_out);
        if (expect_out) ch_q[c].push_back(b);
        send_frame(HOSTLINE, HBIT, {6'b100000, 2'(c)});
        send_frame(HOSTLINE, HBIT, b);
    endtask

    task automatic set_rate(int c, int code);
        ch_bit[c] = bit_clks(code);
        send_frame(HOSTLINE, HBIT, {4'b1100, 2'(c), 2'(code)});
    endtask

    task automatic device_send(int c, logic [7:0] b, bit expect_out);
        if (expect_out) begin
            host_q.push_back(8'(c));
            host_q.push_back(b);
        end
        send_frame(c, ch_bit[c], b);
    endtask

    // monitors: decode each line at mid-bit from the falling start edge
    for (genvar g = 0; g < 4; g++) begin : g_mon
        initial begin
            int b;
            logic [7:0] got;
            logic [7:0] exp;
            bit ok;
            forever begin
                @(negedge clk);
                if (ch_txd[g] === 1'b0) begin
                    b = ch_bit[g];
                    repeat (b / 2) @(negedge clk);
                    ok = (ch_txd[g] === 1'b0);
                    for (int i = 0; i < 8; i++) begin
                        repeat (b) @(negedge clk);
                        got[i] = ch_txd[g];
                    end
                    repeat (b) @(negedge clk);
                    ok = ok && (ch_txd[g] === 1'b1);
                    ch_frames[g]++;
                    if (ch_q[g].size() == 0) begin
                        check(0, "R4", $sformatf("unexpected frame on ch%0d", g), got, 0);
                    end else begin
                        exp = ch_q[g].pop_front();
                        check(ok, "R5", $sformatf("framing on ch%0d", g), ok, 1);
                        check(got == exp, "R7", $sformatf("byte on ch%0d", g), got, exp);
                    end
                end
            end
        end
    end

    initial begin
        logic [7:0] got;
        logic [7:0] exp;
        bit ok;
        forever begin
            @(negedge clk);
            if (host_txd === 1'b0) begin
                repeat (HBIT / 2) @(negedge clk);
                ok = (host_txd === 1'b0);
                for (int i = 0; i < 8; i++) begin
                    repeat (HBIT) @(negedge clk);
                    got[i] = host_txd;
                end
                repeat (HBIT) @(negedge clk);
                ok = ok && (host_txd === 1'b1);
                host_frames++;
                if (host_q.size() == 0) begin
                    check(0, "R8", "unexpected host frame", got, 0);
                end else begin
                    exp = host_q.pop_front();
                    check(ok, "R10", "host framing", ok, 1);
                    check(got == exp, "R9", "host byte order", got, exp);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        check(0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic wait_idle(int limit);
        int guard = 0;
        while ((ch_q[0].size() + ch_q[1].size() + ch_q[2].size() + ch_q[3].size()
                + host_q.size()) != 0 && guard < limit) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        for (int c = 0; c < 4; c++) begin
            ch_bit[c] = 0;
            ch_frames[c] = 0;
        end
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1: idle lines after reset
        check(host_txd === 1'b1, "R1", "host_txd after reset", host_txd, 1);
        check(ch_txd === 4'hF, "R1", "ch_txd after reset", ch_txd, 4'hF);

        // R3: headers with top bits 00 and 01 do nothing
        send_frame(HOSTLINE, HBIT, 8'h25);
        send_frame(HOSTLINE, HBIT, 8'h4A);

        // R4: payload to an unconfigured channel stays queued; its input is ignored
        send_payload(0, 8'h11, 1);
        send_payload(0, 8'h22, 1);
        send_payload(0, 8'h3C, 1);
        send_frame(1, 64, 8'h77);
        repeat (1500) @(negedge clk);
        check(ch_txd === 4'hF, "R4", "lines held while unconfigured", ch_txd, 4'hF);
        check(host_frames == 0, "R4", "no return from unconfigured input", host_frames, 0);
        check(ch_frames[0] + ch_frames[1] + ch_frames[2] + ch_frames[3] == 0, "R3",
              "no frames from ignored headers", ch_frames[0], 0);

        // R6: 66 bytes to an unconfigured channel, only 64 kept
        for (int i = 0; i < 66; i++) send_payload(3, 8'(i * 3 + 1), i < 64);
        check(ch_txd[3] === 1'b1, "R4", "ch3 held before rate", ch_txd[3], 1);

        // R2: give each channel its own rate
        set_rate(0, 0);
        set_rate(1, 1);
        set_rate(2, 2);
        set_rate(3, 3);

        // R7: distinct bursts while others are transmitting
        send_payload(1, 8'hA1, 1);
        send_payload(2, 8'hB2, 1);
        send_payload(3, 8'hC3, 1);
        send_payload(1, 8'h5E, 1);
        send_payload(2, 8'h0F, 1);
        send_payload(3, 8'hF0, 1);
        send_payload(1, 8'h81, 1);
        send_payload(2, 8'h7E, 1);
        send_payload(3, 8'h99, 1);
        send_payload(3, 8'h42, 1);
        wait_idle(100000);
        repeat (8000) @(negedge clk);
        check(ch_frames[3] == 68, "R6", "ch3 frame count", ch_frames[3], 68);
        check(ch_frames[0] == 3, "R4", "ch0 held bytes sent", ch_frames[0], 3);
        check(ch_frames[1] == 3 && ch_frames[2] == 3, "R7", "ch1/ch2 frame count",
              ch_frames[1] + ch_frames[2], 6);

        // R9: ch3 (fast) and ch2 both deliver two bytes. The first grant goes to
        // ch3, and after that the pointer rotation alternates ch2, ch3, ch2.
        host_q.push_back(8'd3); host_q.push_back(8'hD1);
        host_q.push_back(8'd2); host_q.push_back(8'hE2);
        host_q.push_back(8'd3); host_q.push_back(8'hD3);
        host_q.push_back(8'd2); host_q.push_back(8'hE4);
        fork
            begin
                device_send(3, 8'hD1, 0);
                device_send(3, 8'hD3, 0);
            end
            begin
                device_send(2, 8'hE2, 0);
                device_send(2, 8'hE4, 0);
            end
        join
        wait_idle(20000);

        // R8: return path from the slow channels
        device_send(0, 8'hC5, 1);
        wait_idle(20000);
        device_send(1, 8'h3A, 1);
        wait_idle(20000);
        repeat (2000) @(negedge clk);

        check(host_frames == 12, "R8", "host frame count", host_frames, 12);
        check(host_q.size() == 0, "R9", "host scoreboard drained", host_q.size(), 0);
        check(host_txd === 1'b1 && ch_txd === 4'hF, "R5", "lines idle high at end",
              {host_txd, ch_txd}, 5'h1F);
        finish_run();
    end
endmodule